// File: doc/BRIEF.md
# Event Hit Memory with Token-Chain Readout

This block is the per-chip event store of a self-triggered multi-channel front end. Each trigger strobe captures a complete snapshot of the chip: two discriminator bits for every one of the 64 channels, the current 24-bit bunch-crossing count, and an 8-bit header carrying the fixed chip identifier. All channels are written on every trigger, including channels with no hit. Up to 128 snapshots are held in an on-chip frame memory.

Readout is shared by a chain of up to 100 chips. A token travels along the chain, and only the chip that holds it drives the serial line. On receiving the token, the chip streams every stored frame in storage order, with no gap between frames. It then hands the token to the next chip and clears its memory for the next acquisition. A chip that holds nothing passes the token on almost at once.

The controller has four states. IDLE accepts triggers and waits for the token. LOAD fetches the first frame, or detects an empty memory. SHIFT streams bits and reloads each following frame at a frame boundary. PASS raises token-out and clears the pointers. The transitions are: IDLE→LOAD on token-in; LOAD→PASS when empty; LOAD→SHIFT otherwise; SHIFT→SHIFT at each frame boundary while frames remain; SHIFT→PASS after the last bit; PASS→IDLE unconditionally.

Top module: `hit_token_mem`

## Requirements
- R1: A frame is 160 bits. Bits [159:152] hold `chip_id_i`, bits [151:128] hold `bcid_i` and bits [127:0] hold `disc_i`, with channel c at bits [2c+1:2c]. Frames are sent most significant bit first, so the header leads.
- R2: A trigger taken in IDLE while the memory is not full stores one frame built from the inputs at that clock edge, even when all discriminator bits are zero.
- R3: Once 128 frames are stored, `full_o` is high and further triggers store nothing.
- R4: When `token_i` is sampled high in IDLE, every stored frame is sent oldest first as one unbroken run of `dvalid_o`-qualified bits. The first bit appears in the second cycle after the sampling edge, and `dout_o` is 0 whenever `dvalid_o` is low.
- R5: `token_o` is high for exactly one cycle, in the cycle after the last data bit. For n frames, that is cycle 2+160·n counted from the edge that sampled the token.
- R6: With no frames stored, `token_o` rises in the second cycle after the token is sampled, and `dvalid_o` stays low.
- R7: Readout clears the write pointer and `full_o`. The next acquisition starts at frame 0, and the next readout carries only the frames stored after the clear.
- R8: Triggers that arrive while a readout is in progress are ignored.
- R9: A trigger in the same cycle that `token_i` is sampled in IDLE is stored and included in that readout as its last frame.
- R10: After reset, `dout_o`, `dvalid_o`, `token_o` and `full_o` are all 0 and the memory is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger strobe; stores one frame |
| disc_i | input | 128 | Discriminator bits, two per channel |
| bcid_i | input | 24 | Bunch-crossing counter |
| chip_id_i | input | 8 | Fixed chip identifier, used as the header |
| token_i | input | 1 | Readout token from the previous chip |
| dout_o | output | 1 | Serial frame data |
| dvalid_o | output | 1 | Qualifies `dout_o` |
| token_o | output | 1 | Token to the next chip, one-cycle pulse |
| full_o | output | 1 | Memory holds 128 frames |

## Verification
Two functions can land in the same cycle: capturing a trigger and starting a readout. The bench drives `trig_i` and `token_i` together in one cycle and expects the new frame to appear as the last frame of that same stream (R9). It also strobes a trigger in the middle of a stream and expects neither extra bits nor a shifted token-out cycle (R8). Both cases are judged on the bit-exact stream and on the exact cycle of `token_o`.

// File: rtl/hm_pkg.sv
package hm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PASS  = 2'd3
    } hm_state_e;
endpackage

// File: rtl/hm_store.sv
module hm_store #(
    parameter int FW    = 160,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_req_i,
    input  logic [FW-1:0] wr_data_i,
    input  logic          clr_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [FW-1:0] rd_data_o,
    output logic [PW-1:0] count_o,
    output logic          full_o
);
    logic [FW-1:0] mem_q [DEPTH];
    logic [PW-1:0] cnt_q;
    logic          do_wr;

    assign full_o    = (cnt_q == PW'(DEPTH));
    assign do_wr     = wr_req_i && !full_o;
    assign count_o   = cnt_q;
    assign rd_data_o = mem_q[rd_idx_i];

    always_ff @(posedge clk_i) begin
        if (do_wr) begin
            mem_q[cnt_q[AW-1:0]] <= wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (do_wr) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= PW'(DEPTH));

    assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && wr_req_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hm_serializer.sv
module hm_serializer #(
    parameter int FW  = 160,
    localparam int CW = $clog2(FW)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [FW-1:0] load_data_i,
    input  logic          shift_i,
    output logic          msb_o,
    output logic          last_o
);
    logic [FW-1:0] sh_q;
    logic [CW-1:0] bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (load_i) begin
            sh_q  <= load_data_i;
            bit_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[FW-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
        end
    end

    assign msb_o  = sh_q[FW-1];
    assign last_o = (bit_q == CW'(FW - 1));

    assert_load_shift_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && shift_i));
endmodule

// File: rtl/hm_token_fsm.sv
module hm_token_fsm
    import hm_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          token_i,
    input  logic [PW-1:0] count_i,
    input  logic          ser_last_i,
    output logic          wr_allow_o,
    output logic          load_o,
    output logic          shift_o,
    output logic          clr_o,
    output logic [AW-1:0] rd_idx_o,
    output logic          dvalid_o,
    output logic          token_o
);
    hm_state_e     state_q, state_d;
    logic [PW-1:0] rd_q;
    logic          more;
    logic          empty;

    assign more     = (rd_q != count_i);
    assign empty    = (count_i == '0);
    assign rd_idx_o = rd_q[AW-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (token_i) state_d = ST_LOAD;
            ST_LOAD:  state_d = empty ? ST_PASS : ST_SHIFT;
            ST_SHIFT: if (ser_last_i && !more) state_d = ST_PASS;
            ST_PASS:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        wr_allow_o = 1'b0;
        load_o     = 1'b0;
        shift_o    = 1'b0;
        clr_o      = 1'b0;
        dvalid_o   = 1'b0;
        token_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_allow_o = 1'b1;
            ST_LOAD:  load_o = !empty;
            ST_SHIFT: begin
                dvalid_o = 1'b1;
                load_o   = ser_last_i && more;
                shift_o  = !ser_last_i;
            end
            ST_PASS: begin
                token_o = 1'b1;
                clr_o   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     rd_q <= '0;
        else if (clr_o)  rd_q <= '0;
        else if (load_o) rd_q <= rd_q + 1'b1;
    end

    assert_token_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        token_o |=> !token_o);

    assert_clear_after_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        token_o |=> (count_i == '0));

    assert_empty_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOAD && empty) |=> token_o);

    assert_valid_needs_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dvalid_o |-> !empty);

    assert_no_store_in_readout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dvalid_o && !clr_o) |=> $stable(count_i));
endmodule

// File: rtl/hit_token_mem.sv
module hit_token_mem #(
    parameter int NCH   = 64,
    parameter int DBITS = 2,
    parameter int TSW   = 24,
    parameter int HDRW  = 8,
    parameter int DEPTH = 128,
    localparam int HW   = NCH * DBITS,
    localparam int FW   = HDRW + TSW + HW,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            trig_i,
    input  logic [HW-1:0]   disc_i,
    input  logic [TSW-1:0]  bcid_i,
    input  logic [HDRW-1:0] chip_id_i,
    input  logic            token_i,
    output logic            dout_o,
    output logic            dvalid_o,
    output logic            token_o,
    output logic            full_o
);
    logic [FW-1:0] frame;
    logic [FW-1:0] rd_data;
    logic [PW-1:0] count;
    logic [AW-1:0] rd_idx;
    logic          wr_allow, load, shift, clr, ser_last, msb, valid;

    assign frame = {chip_id_i, bcid_i, disc_i};

    hm_store #(.FW(FW), .DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_req_i  (trig_i && wr_allow),
        .wr_data_i (frame),
        .clr_i     (clr),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .count_o   (count),
        .full_o    (full_o)
    );

    hm_serializer #(.FW(FW)) u_ser (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load),
        .load_data_i (rd_data),
        .shift_i     (shift),
        .msb_o       (msb),
        .last_o      (ser_last)
    );

    hm_token_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .token_i    (token_i),
        .count_i    (count),
        .ser_last_i (ser_last),
        .wr_allow_o (wr_allow),
        .load_o     (load),
        .shift_o    (shift),
        .clr_o      (clr),
        .rd_idx_o   (rd_idx),
        .dvalid_o   (valid),
        .token_o    (token_o)
    );

    assign dvalid_o = valid;
    assign dout_o   = valid & msb;

    assert_quiet_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dvalid_o |-> !dout_o);
endmodule

// File: tb/test_hit_token_mem.sv
`timescale 1ns/1ps
module test_hit_token_mem;
    localparam int FW    = 160;
    localparam int DEPTH = 128;
    localparam logic [7:0] CHIP = 8'h5C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig = 1'b0;
    logic [127:0] disc = '0;
    logic [23:0]  bcid = '0;
    logic         token = 1'b0;
    logic         dout, dvalid, token_out, full;

    int checks = 0;
    int errors = 0;
    logic [FW-1:0] exp_f [DEPTH];
    int exp_n = 0;

    always #4 clk = ~clk;

    hit_token_mem i_hit_token_mem (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .disc_i(disc),
        .bcid_i(bcid), .chip_id_i(CHIP), .token_i(token),
        .dout_o(dout), .dvalid_o(dvalid), .token_o(token_out), .full_o(full)
    );

    function automatic logic [FW-1:0] mk_frame(input logic [127:0] h, input logic [23:0] b);
        return {CHIP, b, h};
    endfunction

    function automatic logic [127:0] rnd_hits();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_trig(input logic [127:0] h, input logic [23:0] b);
        @(negedge clk);
        trig = 1'b1; disc = h; bcid = b;
        if (exp_n < DEPTH) begin
            exp_f[exp_n] = mk_frame(h, b);
            exp_n++;
        end
        @(negedge clk);
        trig = 1'b0;
    endtask

    // with_trig: trigger in the token cycle (R9); inject: trigger mid-stream (R8)
    task automatic readout(input string tag, input bit with_trig, input bit inject);
        int cyc;
        int nbits;
        int bad;
        int first_bad;
        logic [127:0] h;
        logic [23:0] b;
        h = rnd_hits(); b = 24'($urandom);
        @(negedge clk);
        token = 1'b1;
        if (with_trig) begin
            trig = 1'b1; disc = h; bcid = b;
            if (exp_n < DEPTH) begin
                exp_f[exp_n] = mk_frame(h, b);
                exp_n++;
            end
        end
        @(negedge clk);
        token = 1'b0; trig = 1'b0;
        cyc = 1; nbits = 0; bad = 0; first_bad = -1;
        while (!token_out && cyc < 30000) begin
            if (dvalid) begin
                if (nbits < exp_n * FW) begin
                    if (dout !== exp_f[nbits / FW][FW - 1 - (nbits % FW)]) begin
                        bad++;
                        if (first_bad < 0) first_bad = nbits;
                    end
                end
                nbits++;
            end else if (dout !== 1'b0) begin
                bad++;
            end
            @(negedge clk);
            trig = (inject && cyc == 50);
            cyc++;
        end
        trig = 1'b0;
        chk(nbits == exp_n * FW, {tag, " R4 bit count"}, nbits, exp_n * FW);
        chk(bad == 0, {tag, " R1 R4 stream content, first bad bit"}, first_bad, -1);
        chk(cyc == 2 + exp_n * FW, {tag, " R5 token_o cycle"}, cyc, 2 + exp_n * FW);
        @(negedge clk);
        chk(token_out == 1'b0, {tag, " R5 token_o one cycle"}, token_out, 0);
        chk(full == 1'b0, {tag, " R7 full cleared"}, full, 0);
        exp_n = 0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(dout == 1'b0, "R10 dout in reset", dout, 0);
        chk(dvalid == 1'b0, "R10 dvalid in reset", dvalid, 0);
        chk(token_out == 1'b0, "R10 token_o in reset", token_out, 0);
        chk(full == 1'b0, "R10 full in reset", full, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: empty chip passes token in cycle 2
        readout("empty R6", 1'b0, 1'b0);

        // R1 R2: all-zero, all-one and random frames
        do_trig('0, 24'h000000);
        do_trig('1, 24'hFFFFFF);
        do_trig({64{2'b01}}, 24'h123456);
        for (int i = 0; i < 3; i++) do_trig(rnd_hits(), 24'($urandom));
        readout("basic R2", 1'b0, 1'b0);

        // R9 same-cycle trigger and token, R8 trigger during stream
        for (int i = 0; i < 3; i++) do_trig(rnd_hits(), 24'($urandom));
        readout("collide R9 R8", 1'b1, 1'b1);

        // R9 alone on an empty memory: the trigger becomes the only frame
        readout("collide-empty R9", 1'b1, 1'b0);

        // R3 fill to the limit and beyond
        for (int i = 0; i < DEPTH - 1; i++) do_trig(rnd_hits(), 24'($urandom));
        chk(full == 1'b0, "R3 not full at 127", full, 0);
        do_trig(rnd_hits(), 24'($urandom));
        chk(full == 1'b1, "R3 full at 128", full, 1);
        do_trig(rnd_hits(), 24'($urandom));
        do_trig(rnd_hits(), 24'($urandom));
        chk(full == 1'b1, "R3 full holds after drops", full, 1);
        chk(exp_n == DEPTH, "R3 model depth", exp_n, DEPTH);
        readout("full R3", 1'b0, 1'b0);

        // R7 next acquisition restarts at frame 0
        do_trig(rnd_hits(), 24'($urandom));
        do_trig(rnd_hits(), 24'($urandom));
        readout("restart R7", 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule